// File: doc/BRIEF.md
# Source-Routed Wormhole Switch Stage

This block is the input-side routing and switching stage of a five-port mesh router. Each of the ports, north, east, south, west and local, delivers one 34-bit flit per cycle. The two top bits of a flit give its kind. A header carries its own route: a packed list of two-bit hop codes and a four-bit hop count. At each router the block reads the lowest code. It then shifts the list right by one code and lowers the count before the header leaves. When the count and the list are both zero, the packet has arrived and goes to the local port.

Packets move by wormhole switching. A header that wins an output keeps that output for its input until the flit that ends the packet has gone through. Body and tail flits then follow it without being routed again. Headers that meet at a free output are ordered by a round-robin arbiter kept for each output. Each output also keeps a credit count of free slots in the buffer downstream. A flit leaves only while that count is nonzero, and a one-cycle pulse from downstream returns one credit.

The upstream side holds its flit on `in_flit_i` while `in_valid_i` is high. It drops the flit after any cycle in which `in_ready_o` was high. `in_ready_o` is combinational in the same cycle. The forwarded flit appears on the output registers one cycle later.

Top module: `wh_router`

## Requirements
- R1: After reset, every `out_valid_o` bit is low, every output is unlocked, every round-robin pointer points at port 0, and every output holds CREDIT_DEPTH (default 4) credits.
- R2: Flit bit 33 is begin-of-packet and bit 32 is end-of-packet. A flit with bit 33 set arriving on an idle input is a header. The header's payload bits 31:28 are the hop count and bits 27:0 are the path. Unless the packet is for local delivery, the header goes to the output named by path bits 1:0, coded 00 north (port 0), 01 east (port 1), 10 south (port 2) and 11 west (port 3).
- R3: A header sent to a neighbour leaves with its path shifted right by two bits and its hop count lowered by one. A hop count already at zero stays at zero. A header whose hop count and path are both zero goes to the local output (port 4) with no change.
- R4: A header whose bit 32 is clear locks its output to its input. Every later flit on that input goes to the same output, whatever its bits hold. While the lock stands, the output serves no other input. The lock clears when a flit with bit 32 set passes.
- R5: A single-flit packet has bits 33 and 32 both set. It is routed like a header and leaves its output unlocked, so another input can win that output in the next cycle.
- R6: When several idle inputs have headers for the same free output, that output grants the first requester at or after its pointer, counting upward and wrapping after port 4. After the grant the pointer moves to the port just after the winner.
- R7: An output with zero credits sends nothing. Each flit sent uses one credit. Each `credit_ret_i` pulse adds one credit. A send and a return in the same cycle leave the count unchanged.
- R8: A flit is taken (`in_ready_o` high) in the same cycle it is offered. It appears on `out_valid_o`/`out_flit_o` one clock later with only the header rewrite of R3 applied.
- R9: A flit with bit 33 clear that arrives on an idle input is taken at once and thrown away. It produces no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 5 | Flit offered on each input port (0 N, 1 E, 2 S, 3 W, 4 local) |
| in_flit_i | input | 5x34 | Offered flit for each input port |
| in_ready_o | output | 5 | Offered flit taken this cycle |
| out_valid_o | output | 5 | Flit present on each output port |
| out_flit_o | output | 5x34 | Forwarded flit for each output port |
| credit_ret_i | input | 5 | One-cycle credit return pulse from each downstream buffer |

## Verification
`in_ready_o` is combinational, so the bench applies inputs at the falling edge and checks acceptance 1 ns later, in the same cycle. Each accepted flit is due on the output registers at the next rising edge, and the bench checks it at the falling edge that follows. The behavioural model works out the grants, the rewritten headers and the next lock, pointer and credit state from the same sampled inputs, so every prediction lines up with the register stage it belongs to. A credit return pulse driven in one cycle counts toward the grant decision of the next cycle. The directed phases stress the lock span, the rotation among five contenders, the credit stall and the thrown-away stray flits.

// File: rtl/wh_router_pkg.sv
package wh_router_pkg;
  localparam int FLIT_W  = 34;
  localparam int BOP_BIT = 33;
  localparam int EOP_BIT = 32;
  localparam int HOP_W   = 4;
  localparam int HOP_LSB = 28;
  localparam int PATH_W  = 28;
  localparam int N_PORTS = 5;
  localparam int DIR_W   = $clog2(N_PORTS);

  typedef enum logic [DIR_W-1:0] {
    PORT_N = 3'd0,
    PORT_E = 3'd1,
    PORT_S = 3'd2,
    PORT_W = 3'd3,
    PORT_L = 3'd4
  } port_e;

  typedef logic [FLIT_W-1:0] flit_t;
endpackage

// File: rtl/wh_route_dec.sv
module wh_route_dec
  import wh_router_pkg::*;
(
  input  flit_t            flit_i,
  output logic [DIR_W-1:0] dir_o,
  output flit_t            fwd_o
);
  logic [HOP_W-1:0]  hop;
  logic [PATH_W-1:0] path;
  logic              arrived;

  assign hop     = flit_i[HOP_LSB +: HOP_W];
  assign path    = flit_i[PATH_W-1:0];
  assign arrived = (hop == '0) && (path == '0);

  always_comb begin
    if (arrived) begin
      dir_o = PORT_L;
      fwd_o = flit_i;
    end else begin
      dir_o = DIR_W'(path[1:0]);
      fwd_o = {flit_i[BOP_BIT], flit_i[EOP_BIT],
               (hop == '0) ? hop : hop - HOP_W'(1),
               path >> 2};
    end
  end
endmodule

// File: rtl/wh_rr_arb.sv
module wh_rr_arb #(
  parameter int N = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] req_i,
  output logic [N-1:0] gnt_o
);
  localparam int PW = (N > 1) ? $clog2(N) : 1;

  logic [PW-1:0] ptr_q, ptr_d;

  always_comb begin
    logic found;
    found = 1'b0;
    gnt_o = '0;
    ptr_d = ptr_q;
    for (int k = 0; k < N; k++) begin
      int idx;
      idx = int'(ptr_q) + k;
      if (idx >= N) idx = idx - N;
      if (!found && req_i[idx]) begin
        found      = 1'b1;
        gnt_o[idx] = 1'b1;
        ptr_d      = (idx == N - 1) ? '0 : PW'(idx + 1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ptr_q <= '0;
    else if (|gnt_o) ptr_q <= ptr_d;
  end

  // R6
  onehot_gnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o));

  // R6
  gnt_in_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o & ~req_i) == '0);
endmodule

// File: rtl/wh_credit_cnt.sv
module wh_credit_cnt #(
  parameter int DEPTH = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic take_i,
  input  logic ret_i,
  output logic avail_o
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= CW'(DEPTH);
    else begin
      case ({take_i, ret_i})
        2'b10:   cnt_q <= cnt_q - CW'(1);
        2'b01:   cnt_q <= cnt_q + CW'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign avail_o = (cnt_q != '0);

  // R7
  no_underflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |-> (cnt_q != '0));

  // R7
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH));
endmodule

// File: rtl/wh_router.sv
module wh_router
  import wh_router_pkg::*;
#(
  parameter int CREDIT_DEPTH = 4
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic [N_PORTS-1:0]              in_valid_i,
  input  logic [N_PORTS-1:0][FLIT_W-1:0]  in_flit_i,
  output logic [N_PORTS-1:0]              in_ready_o,
  output logic [N_PORTS-1:0]              out_valid_o,
  output logic [N_PORTS-1:0][FLIT_W-1:0]  out_flit_o,
  input  logic [N_PORTS-1:0]              credit_ret_i
);
  localparam int NP = N_PORTS;

  logic [NP-1:0][DIR_W-1:0] dir;
  flit_t [NP-1:0]           fwd_flit;
  flit_t [NP-1:0]           sel_flit;
  logic  [NP-1:0]           stray;

  logic [NP-1:0]            busy_q;
  logic [NP-1:0][DIR_W-1:0] dst_q;
  logic [NP-1:0]            lock_q;
  logic [NP-1:0][DIR_W-1:0] owner_q;

  logic [NP-1:0][NP-1:0]    req;      // [out][in]
  logic [NP-1:0][NP-1:0]    arb_req;
  logic [NP-1:0][NP-1:0]    arb_gnt;
  logic [NP-1:0][NP-1:0]    grant;
  logic [NP-1:0][NP-1:0]    gcol;     // [in][out]
  logic [NP-1:0]            cred_ok;
  logic [NP-1:0]            out_any;
  logic [NP-1:0][DIR_W-1:0] out_idx;
  flit_t [NP-1:0]           out_sel;
  logic [NP-1:0]            in_any;
  logic [NP-1:0][DIR_W-1:0] in_idx;

  for (genvar i = 0; i < NP; i++) begin : g_dec
    wh_route_dec u_dec (
      .flit_i (in_flit_i[i]),
      .dir_o  (dir[i]),
      .fwd_o  (fwd_flit[i])
    );
  end

  always_comb begin
    for (int i = 0; i < NP; i++) begin
      stray[i]    = in_valid_i[i] && !busy_q[i] && !in_flit_i[i][BOP_BIT];
      sel_flit[i] = busy_q[i] ? in_flit_i[i] : fwd_flit[i];
      for (int o = 0; o < NP; o++) begin
        req[o][i] = in_valid_i[i] &&
                    (busy_q[i] ? (dst_q[i] == DIR_W'(o))
                               : (in_flit_i[i][BOP_BIT] && dir[i] == DIR_W'(o)));
        arb_req[o][i] = req[o][i] && !busy_q[i] && !lock_q[o] && cred_ok[o];
      end
    end
  end

  for (genvar o = 0; o < NP; o++) begin : g_out
    wh_rr_arb #(.N(NP)) u_arb (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .req_i  (arb_req[o]),
      .gnt_o  (arb_gnt[o])
    );

    wh_credit_cnt #(.DEPTH(CREDIT_DEPTH)) u_cred (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .take_i  (out_any[o]),
      .ret_i   (credit_ret_i[o]),
      .avail_o (cred_ok[o])
    );
  end

  always_comb begin
    for (int o = 0; o < NP; o++) begin
      out_idx[o] = '0;
      out_sel[o] = '0;
      for (int i = 0; i < NP; i++) begin
        grant[o][i] = lock_q[o] ? (req[o][i] && owner_q[o] == DIR_W'(i) && cred_ok[o])
                                : arb_gnt[o][i];
        gcol[i][o]  = grant[o][i];
        if (grant[o][i]) begin
          out_idx[o] = DIR_W'(i);
          out_sel[o] = sel_flit[i];
        end
      end
      out_any[o] = |grant[o];
    end
    for (int i = 0; i < NP; i++) begin
      in_idx[i] = '0;
      for (int o = 0; o < NP; o++) begin
        if (gcol[i][o]) in_idx[i] = DIR_W'(o);
      end
      in_any[i]     = |gcol[i];
      in_ready_o[i] = stray[i] || in_any[i];
    end
  end

  // output registers and lock state
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= '0;
      out_flit_o  <= '0;
      lock_q      <= '0;
      owner_q     <= '0;
    end else begin
      for (int o = 0; o < NP; o++) begin
        out_valid_o[o] <= out_any[o];
        if (out_any[o]) out_flit_o[o] <= out_sel[o];
        if (out_any[o]) begin
          if (lock_q[o]) begin
            if (out_sel[o][EOP_BIT]) lock_q[o] <= 1'b0;
          end else if (!out_sel[o][EOP_BIT]) begin
            lock_q[o]  <= 1'b1;
            owner_q[o] <= out_idx[o];
          end
        end
      end
    end
  end

  // per-input packet state
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= '0;
      dst_q  <= '0;
    end else begin
      for (int i = 0; i < NP; i++) begin
        if (in_any[i]) begin
          if (busy_q[i]) begin
            if (in_flit_i[i][EOP_BIT]) busy_q[i] <= 1'b0;
          end else if (!in_flit_i[i][EOP_BIT]) begin
            busy_q[i] <= 1'b1;
            dst_q[i]  <= in_idx[i];
          end
        end
      end
    end
  end

  for (genvar i = 0; i < NP; i++) begin : g_in_chk
    // R4
    one_out_per_in_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(gcol[i]));
  end

  for (genvar o = 0; o < NP; o++) begin : g_out_chk
    // R4
    lock_owner_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      lock_q[o] |-> (busy_q[owner_q[o]] && dst_q[owner_q[o]] == DIR_W'(o)));
  end
endmodule

// File: tb/wh_router_tb.sv
`timescale 1ns/1ps
module wh_router_tb;
  localparam int NP    = 5;
  localparam int DEPTH = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NP-1:0]        in_valid = '0;
  logic [NP-1:0][33:0]  in_flit  = '0;
  logic [NP-1:0]        in_ready;
  logic [NP-1:0]        out_valid;
  logic [NP-1:0][33:0]  out_flit;
  logic [NP-1:0]        cred_ret = '0;

  always #2.5 clk = ~clk;

  wh_router #(.CREDIT_DEPTH(DEPTH)) u_dut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .in_valid_i   (in_valid),
    .in_flit_i    (in_flit),
    .in_ready_o   (in_ready),
    .out_valid_o  (out_valid),
    .out_flit_o   (out_flit),
    .credit_ret_i (cred_ret)
  );

  int total = 0;
  int bad   = 0;
  string tag = "R1";

  logic [33:0] srcq [NP][$];
  int pending [NP];
  bit ret_en [NP];
  int nout = 0;

  // reference model state
  int  m_cred [NP];
  int  m_ptr  [NP];
  bit  m_lock [NP];
  int  m_own  [NP];
  bit  m_busy [NP];
  int  m_dst  [NP];
  bit  exp_ov [NP];
  logic [33:0] exp_of [NP];

  function automatic logic [33:0] mk(bit b, bit e, int hop, int path);
    return {b, e, 4'(hop), 28'(path)};
  endfunction

  function automatic logic [33:0] dat(bit e, int v);
    return {1'b0, e, 32'(v)};
  endfunction

  function automatic int route(logic [33:0] f);
    if (f[31:28] == 0 && f[27:0] == 0) return 4;
    return int'(f[1:0]);
  endfunction

  function automatic logic [33:0] rewrite(logic [33:0] f);
    logic [3:0] h;
    if (f[31:28] == 0 && f[27:0] == 0) return f;
    h = (f[31:28] == 0) ? 4'd0 : f[31:28] - 4'd1;
    return {f[33:32], h, f[27:0] >> 2};
  endfunction

  task automatic chk(bit ok, string what, logic [33:0] act, logic [33:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  task automatic step();
    int g [NP];
    bit vin [NP];
    logic [33:0] fl [NP];
    bit take;
    @(negedge clk);
    // R8: registered outputs of the previous cycle
    for (int o = 0; o < NP; o++) begin
      chk(out_valid[o] == exp_ov[o], $sformatf("out_valid[%0d]", o),
          34'(out_valid[o]), 34'(exp_ov[o]));
      if (exp_ov[o] && out_valid[o])
        chk(out_flit[o] == exp_of[o], $sformatf("out_flit[%0d]", o), out_flit[o], exp_of[o]);
      if (out_valid[o]) begin
        pending[o]++;
        nout++;
      end
    end
    for (int i = 0; i < NP; i++) begin
      vin[i] = srcq[i].size() > 0;
      fl[i]  = vin[i] ? srcq[i][0] : '0;
      in_valid[i] = vin[i];
      in_flit[i]  = fl[i];
    end
    for (int o = 0; o < NP; o++) begin
      cred_ret[o] = ret_en[o] && pending[o] > 0;
      if (cred_ret[o]) pending[o]--;
    end
    #1;
    for (int o = 0; o < NP; o++) begin
      g[o] = -1;
      if (m_cred[o] > 0) begin
        if (m_lock[o]) begin
          if (vin[m_own[o]]) g[o] = m_own[o];
        end else begin
          for (int k = 0; k < NP; k++) begin
            int c;
            c = (m_ptr[o] + k) % NP;
            if (g[o] < 0 && vin[c] && !m_busy[c] && fl[c][33] && route(fl[c]) == o) g[o] = c;
          end
        end
      end
    end
    for (int i = 0; i < NP; i++) begin
      take = vin[i] && !m_busy[i] && !fl[i][33];
      for (int o = 0; o < NP; o++) if (g[o] == i) take = 1'b1;
      chk(in_ready[i] == take, $sformatf("in_ready[%0d]", i), 34'(in_ready[i]), 34'(take));
      if (take) void'(srcq[i].pop_front());
    end
    for (int o = 0; o < NP; o++) begin
      exp_ov[o] = g[o] >= 0;
      if (g[o] >= 0) begin
        int s;
        s = g[o];
        exp_of[o] = m_busy[s] ? fl[s] : rewrite(fl[s]);
        if (m_lock[o]) begin
          if (fl[s][32]) m_lock[o] = 0;
        end else begin
          m_ptr[o] = (s + 1) % NP;
          if (!fl[s][32]) begin
            m_lock[o] = 1;
            m_own[o]  = s;
          end
        end
        if (m_busy[s]) begin
          if (fl[s][32]) m_busy[s] = 0;
        end else if (!fl[s][32]) begin
          m_busy[s] = 1;
          m_dst[s]  = o;
        end
        m_cred[o]--;
      end
      if (cred_ret[o]) m_cred[o]++;
    end
  endtask

  task automatic drain();
    bit any;
    do begin
      step();
      any = 0;
      for (int i = 0; i < NP; i++) if (srcq[i].size() > 0) any = 1;
    end while (any);
    repeat (4) step();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired in phase %s", tag);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < NP; i++) begin
      m_cred[i] = DEPTH; m_ptr[i] = 0; m_lock[i] = 0; m_own[i] = 0;
      m_busy[i] = 0; m_dst[i] = 0; exp_ov[i] = 0; exp_of[i] = '0;
      pending[i] = 0; ret_en[i] = 1;
    end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state seen at the ports
    chk(out_valid == '0, "out_valid after reset", 34'(out_valid), '0);
    chk(in_ready == '0, "in_ready idle after reset", 34'(in_ready), '0);

    // R2: one single-flit packet per neighbour code, from the local input
    tag = "R2";
    for (int d = 0; d < 4; d++) srcq[4].push_back(mk(1, 1, 1, d));
    drain();

    // R3: multi-hop rewrite, local arrival, hop count already zero
    tag = "R3";
    srcq[4].push_back(mk(1, 1, 3, 28'b10_01_11));
    srcq[0].push_back(mk(1, 1, 0, 0));
    srcq[1].push_back(mk(1, 1, 0, 28'b01_10));
    drain();

    // R4: two packets contend for east, one single to south
    tag = "R4";
    srcq[3].push_back(mk(1, 0, 1, 1));
    srcq[3].push_back(dat(0, 32'hA1));
    srcq[3].push_back(dat(0, 32'hA2));
    srcq[3].push_back(dat(1, 32'hA3));
    srcq[2].push_back(mk(1, 0, 1, 1));
    srcq[2].push_back({2'b10, 32'hB1});  // bit 33 set mid-packet: still follows lock
    srcq[2].push_back(dat(1, 32'hB2));
    srcq[0].push_back(mk(1, 1, 1, 2));
    drain();

    // R5: single-flit packets from two inputs on one output, no lock left
    tag = "R5";
    for (int k = 0; k < 3; k++) begin
      srcq[0].push_back(mk(1, 1, 2, 28'b1111));
      srcq[1].push_back(mk(1, 1, 1, 3));
    end
    drain();

    // R6: five contenders for east
    tag = "R6";
    for (int k = 0; k < 3; k++)
      for (int i = 0; i < NP; i++) srcq[i].push_back(mk(1, 1, 1, 1));
    drain();

    // R7: no credit return on north, stall after DEPTH flits
    tag = "R7";
    ret_en[0] = 0;
    for (int k = 0; k < 6; k++) srcq[4].push_back(mk(1, 1, 1, 0));
    repeat (10) step();
    chk(srcq[4].size() == 2, "flits left with credits exhausted",
        34'(srcq[4].size()), 34'd2);
    ret_en[0] = 1;
    drain();

    // R9: stray body and tail on an idle input are thrown away
    tag = "R9";
    nout = 0;
    srcq[1].push_back(dat(0, 32'hDEAD));
    srcq[1].push_back(dat(1, 32'hBEEF));
    drain();
    chk(nout == 0, "outputs from stray flits", 34'(nout), 34'd0);
    chk(srcq[1].size() == 0, "stray flits taken", 34'(srcq[1].size()), 34'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule